// File: doc/BRIEF.md
# Burst-Ready Generator for a Cache Tag Lookup

This block produces the active-low burst-ready signal that a cache tag store returns to the processor bus. It combines the tag comparison result with the stored valid and write-through policy bits, the direction of the current processor cycle, the tag and status access controls, a force-not-ready input and an external ready input. The external ready input is registered on the rising clock edge. All other inputs reach the output through combinational logic only. The output pin is modelled as a level plus an enable, so the surrounding pad logic can build a three-state driver.

The status-mode select picks between two interpretations of the stored status bits. In dedicated mode the block applies the valid and write-through bits itself. In generic mode those bits are left to the system and have no effect on ready. When no higher-priority rule applies, the level follows the comparison result: a hit gives low (ready) and a miss gives high.

Top module: `burst_ready_gen`

## Requirements
- R1: `rdy_en` is 1 exactly when `rdy_oe_n` is 0, under every other input combination.
- R2: While `rst_n` is 0, `rdy_n` is 1 whatever the other inputs are.
- R3: A rising clock edge with `rst_n` at 0 sets the registered external ready to inactive (1). After reset is released, `ext_rdy_n` has no effect until a rising edge samples it.
- R4: `ext_rdy_n` is sampled on each rising edge. While the sampled value is 0 (and `rst_n` is 1), `rdy_n` is 0 regardless of every lower-priority input.
- R5: With reset released and the sampled external ready at 1, `force_hi` at 1 drives `rdy_n` to 1.
- R6: Below R5 in priority, a tag read (`tag_oe_n` = 0), a tag write (`tag_we_n` = 0) or a status write (`stat_we_n` = 0) drives `rdy_n` to 1.
- R7: Below R6 in priority, in dedicated mode (`generic_mode` = 0) a stored valid bit of 0 drives `rdy_n` to 1.
- R8: Below R6 in priority, in dedicated mode a write cycle (`wr_cycle` = 1) with a stored write-through bit of 1 drives `rdy_n` to 1.
- R9: In generic mode (`generic_mode` = 1), `valid_bit` and `wthru_bit` have no effect on `rdy_n`.
- R10: When none of R2 to R8 applies, `rdy_n` equals the inverse of `hit`: 0 on a hit, 1 on a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers the external ready input on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also forces ready inactive while low |
| hit | input | 1 | Tag comparison result, 1 = stored tag equals the lookup tag |
| valid_bit | input | 1 | Stored valid bit of the addressed entry |
| wthru_bit | input | 1 | Stored write-through bit of the addressed entry |
| generic_mode | input | 1 | 0 = dedicated status use, 1 = generic status use |
| wr_cycle | input | 1 | Processor cycle direction, 1 = write, 0 = read |
| force_hi | input | 1 | 1 forces ready inactive |
| ext_rdy_n | input | 1 | External active-low ready, sampled on the clock |
| tag_oe_n | input | 1 | Active-low tag read enable |
| tag_we_n | input | 1 | Active-low tag write enable |
| stat_we_n | input | 1 | Active-low status write enable |
| rdy_oe_n | input | 1 | Active-low enable for the ready pin |
| rdy_n | output | 1 | Ready level, active low |
| rdy_en | output | 1 | 1 = ready pin driven, 0 = released |

## Verification
The in-line properties check, on every clock, the reset override, the effect of the sampled external ready on the edge after sampling, and each rule that forces ready inactive (force input, tag or status access, invalid entry, write-through write) whenever the registered external ready is inactive. How the rules rank against each other, that generic mode ignores the policy bits, that a hit or a miss reaches the level only when nothing outranks it, and that the external ready register comes out of reset inactive can only be shown by the bench's scenarios. The bench covers these with directed rows of the priority order and with biased random input combinations compared against a model of that order.

// File: rtl/burst_ready_gen.sv
module burst_ready_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic valid_bit,
  input  logic wthru_bit,
  input  logic generic_mode,
  input  logic wr_cycle,
  input  logic force_hi,
  input  logic ext_rdy_n,
  input  logic tag_oe_n,
  input  logic tag_we_n,
  input  logic stat_we_n,
  input  logic rdy_oe_n,
  output logic rdy_n,
  output logic rdy_en
);

  logic ext_q;
  logic busy;
  logic policy_block;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b1;
    else        ext_q <= ext_rdy_n;
  end

  assign busy         = !tag_oe_n || !tag_we_n || !stat_we_n;
  assign policy_block = !generic_mode && (!valid_bit || (wr_cycle && wthru_bit));

  always_comb begin
    if (!rst_n)            rdy_n = 1'b1;
    else if (!ext_q)       rdy_n = 1'b0;
    else if (force_hi)     rdy_n = 1'b1;
    else if (busy)         rdy_n = 1'b1;
    else if (policy_block) rdy_n = 1'b1;
    else                   rdy_n = !hit;
  end

  assign rdy_en = !rdy_oe_n;

  AST_RESET_INACTIVE: assert property (@(posedge clk) !rst_n |-> rdy_n); // R2
  AST_EXT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ext_rdy_n)) |-> !rdy_n); // R4
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q && force_hi) |-> rdy_n); // R5
  AST_ACCESS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q && (!tag_oe_n || !tag_we_n || !stat_we_n)) |-> rdy_n); // R6
  AST_INVALID_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q && !generic_mode && !valid_bit) |-> rdy_n); // R7
  AST_WTHRU_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q && !generic_mode && wr_cycle && wthru_bit) |-> rdy_n); // R8

endmodule

// File: tb/sim_burst_ready_gen.sv
module sim_burst_ready_gen;
  logic clk = 1'b0;
  logic rst_n, hit, valid_bit, wthru_bit, generic_mode, wr_cycle, force_hi;
  logic ext_rdy_n, tag_oe_n, tag_we_n, stat_we_n, rdy_oe_n;
  logic rdy_n, rdy_en;
  logic exp_q;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_ready_gen u0 (
    .clk(clk), .rst_n(rst_n), .hit(hit), .valid_bit(valid_bit),
    .wthru_bit(wthru_bit), .generic_mode(generic_mode), .wr_cycle(wr_cycle),
    .force_hi(force_hi), .ext_rdy_n(ext_rdy_n), .tag_oe_n(tag_oe_n),
    .tag_we_n(tag_we_n), .stat_we_n(stat_we_n), .rdy_oe_n(rdy_oe_n),
    .rdy_n(rdy_n), .rdy_en(rdy_en)
  );

  function automatic int rule_of();
    if (!rst_n) return 2;
    if (!exp_q) return 4;
    if (force_hi) return 5;
    if (!tag_oe_n || !tag_we_n || !stat_we_n) return 6;
    if (!generic_mode && !valid_bit) return 7;
    if (!generic_mode && wr_cycle && wthru_bit) return 8;
    return 10;
  endfunction

  function automatic logic exp_level(int r);
    if (r == 4) return 1'b0;
    if (r == 10) return !hit;
    return 1'b1;
  endfunction

  function automatic string tag_of(int r);
    case (r)
      2: return "R2";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return (generic_mode ? "R9/R10" : "R10");
    endcase
  endfunction

  task automatic check_all(string note);
    int r;
    r = rule_of();
    checks++;
    if (rdy_n !== exp_level(r)) begin
      errors++;
      $display("FAIL %s %s: rdy_n=%b expected %b", tag_of(r), note, rdy_n, exp_level(r));
    end
    checks++;
    if (rdy_en !== !rdy_oe_n) begin
      errors++;
      $display("FAIL R1 %s: rdy_en=%b expected %b", note, rdy_en, !rdy_oe_n);
    end
  endtask

  task automatic idle();
    rst_n = 1; hit = 0; valid_bit = 1; wthru_bit = 0; generic_mode = 0;
    wr_cycle = 0; force_hi = 0; ext_rdy_n = 1; tag_oe_n = 1; tag_we_n = 1;
    stat_we_n = 1; rdy_oe_n = 0;
  endtask

  task automatic cycle(string note);
    @(posedge clk);
    exp_q = rst_n ? ext_rdy_n : 1'b1;
    #1 check_all(note);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    rst_n = 0; hit = 1; ext_rdy_n = 0; force_hi = 1;
    exp_q = 1'b1;
    @(negedge clk);
    cycle("reset holds high");
    cycle("reset holds high again");
    rst_n = 1;
    #1 check_all("R3 register inactive after reset release");
    idle(); hit = 1; cycle("R10 hit gives low");
    hit = 0; cycle("R10 miss gives high");
    hit = 1; ext_rdy_n = 0; force_hi = 1; tag_we_n = 0; valid_bit = 0;
    cycle("R4 external overrides all");
    ext_rdy_n = 1; cycle("R5 force after ext released");
    force_hi = 0; cycle("R6 tag write");
    tag_we_n = 1; tag_oe_n = 0; valid_bit = 1; cycle("R6 tag read");
    tag_oe_n = 1; stat_we_n = 0; cycle("R6 status write");
    stat_we_n = 1; valid_bit = 0; cycle("R7 invalid entry");
    valid_bit = 1; wr_cycle = 1; wthru_bit = 1; cycle("R8 write-through write");
    wr_cycle = 0; cycle("R10 write-through read hits");
    generic_mode = 1; valid_bit = 0; wr_cycle = 1; cycle("R9 generic ignores policy");
    rdy_oe_n = 1; cycle("R1 pin released");
    rdy_oe_n = 0; generic_mode = 0; ext_rdy_n = 0; rst_n = 0; cycle("R2 reset beats ext");
    rst_n = 1; ext_rdy_n = 1; cycle("R3 ext register cleared");

    for (int i = 0; i < 3000; i++) begin
      rst_n        = ($urandom % 40) != 0;
      hit          = $urandom % 2;
      valid_bit    = ($urandom % 5) != 0;
      wthru_bit    = $urandom % 2;
      generic_mode = $urandom % 2;
      wr_cycle     = $urandom % 2;
      force_hi     = ($urandom % 8) == 0;
      ext_rdy_n    = ($urandom % 6) != 0;
      tag_oe_n     = ($urandom % 8) != 0;
      tag_we_n     = ($urandom % 10) != 0;
      stat_we_n    = ($urandom % 10) != 0;
      rdy_oe_n     = ($urandom % 5) == 0;
      cycle("random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule